// File: doc/BRIEF.md
# Averaged Cell Voltage Slope Detector

This block watches the voltage of a cell under fast charge and tells the charge controller when that voltage has stopped rising. It does not convert anything itself. It asks an external converter for conversions through a one-cycle request strobe and takes each result when the converter marks it valid. At a fixed interval it requests a closely spaced burst of conversions and reduces them to one averaged sample. The burst is long enough to span a whole period of mains ripple, so the average cancels that ripple. The block keeps the highest averaged sample seen so far. It raises a one-cycle termination pulse when a new sample has fallen below that peak by the threshold of the selected mode.

Two detection styles are available through a rate-select input. The low and medium settings use peak detection: a long burst and a small drop threshold. The high setting uses negative-delta detection: a burst half as long and a larger threshold. Each setting also has its own hold-off time, counted from the start of fast charge. During hold-off a drop never terminates, but the peak is still tracked. Samples outside a validity window of cell voltage are never allowed to terminate. Over-voltage and over-temperature cut-offs belong to other logic and are unaffected.

A session runs while `enable` is high. Taking `enable` low clears everything. Raising it again starts a fresh fast charge with a cleared peak and a restarted hold-off. All time is counted in pulses of `tick`.

Top module: `vslope_det`

## Requirements
- R1: While `enable` is low, `conv_req` and `term_pulse` stay low and all internal state is cleared. A later session behaves as if no earlier session had taken place: the peak is empty and the hold-off restarts.
- R2: On the cycle after `enable` rises, a burst starts with a request. A new burst starts every SAMPLE_GAP ticks after that. Within a burst, the next request is issued CONV_GAP ticks after the previous conversion was accepted.
- R3: `rate_sel` 00 (low) and 01 (medium) take bursts of 2^LOG2_PK conversions (32 by default). `rate_sel` 10 and 11 (high) take bursts of 2^LOG2_ND conversions (16). The averaged sample is the floor of the burst sum divided by the burst length.
- R4: A valid strobe on `adc_valid` while no request is outstanding has no effect on any sample.
- R5: The peak is empty at the start of a session. The first sample fills it. Any later sample that is higher replaces it, including samples taken during hold-off.
- R6: A sample hits when peak minus sample is at least PVD_DROP LSB in low or medium mode, or at least NDV_DROP LSB in high mode. A smaller drop does not hit.
- R7: A sample can terminate only if it lies strictly between WIN_LO and WIN_HI. Samples outside the window still update the peak.
- R8: Hold-off lasts HOLD_LO, HOLD_MID or HOLD_HI ticks from the start of the session, for low, medium and high respectively. A sample completed inside hold-off never terminates.
- R9: `term_pulse` is high for exactly one cycle, two cycles after the last conversion of the hitting burst is accepted. It fires at most once per session.
- R10: `rate_sel` is captured when `enable` rises. Changing it during a session has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Session enable; a rising edge marks the start of fast charge |
| rate_sel | input | 2 | Rate select: 00 low, 01 medium, 1x high |
| tick | input | 1 | Time base pulse used by every interval counter |
| adc_data | input | ADC_W | Conversion result |
| adc_valid | input | 1 | Marks `adc_data` valid for one cycle |
| conv_req | output | 1 | One-cycle request for a conversion |
| term_pulse | output | 1 | One-cycle termination pulse |

## Verification
A wrong burst count or a wrong averaging shift shows at the ports within one sample interval. The number of requests per burst is off, or a sample that sits exactly on the threshold (or rounds across it) terminates one sample early or late. A peak, hold-off or window error is hidden until the first sample that should, or should not, terminate. The bench therefore places the deciding sample right after the relevant boundary: the hold-off end, the window edges, the exact threshold, and stale state carried across a re-enable. Stray valid strobes are injected into a flat voltage profile, so that any absorption of a stray strobe turns into a false termination in the same sample.

// File: rtl/vslope_pkg.sv
package vslope_pkg;

  // average of a burst: floor(sum / 2^sh)
  function automatic logic [31:0] avg_of(input logic [31:0] sum, input int unsigned sh);
    return sum >> sh;
  endfunction

  // true when sample lies at least thr below peak
  function automatic logic drop_hit(input logic [31:0] peak, input logic [31:0] smp,
                                    input logic [31:0] thr);
    return (peak >= smp) && ((peak - smp) >= thr);
  endfunction

  // strict validity window
  function automatic logic win_ok(input logic [31:0] smp, input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (smp > lo) && (smp < hi);
  endfunction

  // rate select decode: bit 1 selects negative-delta style
  function automatic logic is_ndv(input logic [1:0] sel);
    return sel[1];
  endfunction

endpackage

// File: rtl/vslope_burst.sv
module vslope_burst
  import vslope_pkg::*;
#(
  parameter int unsigned ADC_W      = 12,
  parameter int unsigned LOG2_PK    = 5,
  parameter int unsigned LOG2_ND    = 4,
  parameter int unsigned CONV_GAP   = 57,
  parameter int unsigned SAMPLE_GAP = 1700000,
  parameter int unsigned TW         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             nd_mode,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             adc_valid,
  output logic             conv_req,
  output logic             sample_done,
  output logic [ADC_W-1:0] sample_avg
);
  localparam int unsigned ACC_W = ADC_W + LOG2_PK;
  localparam int unsigned CNT_W = LOG2_PK + 1;

  logic             started, busy, await_q;
  logic [TW-1:0]    intv_cnt, gap_cnt;
  logic [CNT_W-1:0] conv_cnt, burst_last;
  logic [ACC_W-1:0] acc, acc_next;
  int unsigned      avg_sh;
  logic             intv_wrap, burst_go, accept, gap_fire;

  assign burst_last = nd_mode ? CNT_W'((1 << LOG2_ND) - 1) : CNT_W'((1 << LOG2_PK) - 1);
  assign avg_sh     = nd_mode ? LOG2_ND : LOG2_PK;
  assign intv_wrap  = tick && (intv_cnt == TW'(SAMPLE_GAP - 1));
  assign burst_go   = active && !busy && (!started || intv_wrap);
  assign accept     = active && await_q && adc_valid;
  assign acc_next   = acc + ACC_W'(adc_data);
  assign gap_fire   = active && busy && !await_q && tick && (gap_cnt == TW'(CONV_GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0; busy <= 1'b0; await_q <= 1'b0;
      intv_cnt <= '0; gap_cnt <= '0; conv_cnt <= '0; acc <= '0;
      conv_req <= 1'b0; sample_done <= 1'b0; sample_avg <= '0;
    end else if (!active) begin
      started <= 1'b0; busy <= 1'b0; await_q <= 1'b0;
      intv_cnt <= '0; gap_cnt <= '0; conv_cnt <= '0; acc <= '0;
      conv_req <= 1'b0; sample_done <= 1'b0; sample_avg <= '0;
    end else begin
      conv_req    <= 1'b0;
      sample_done <= 1'b0;
      if (!started) begin
        started  <= 1'b1;
        intv_cnt <= '0;
      end else if (tick) begin
        intv_cnt <= intv_wrap ? '0 : intv_cnt + 1'b1;
      end
      if (burst_go) begin
        busy <= 1'b1; await_q <= 1'b1; conv_req <= 1'b1;
        conv_cnt <= '0; acc <= '0; gap_cnt <= '0;
      end else if (accept) begin
        await_q <= 1'b0;
        gap_cnt <= '0;
        if (conv_cnt == burst_last) begin
          busy        <= 1'b0;
          sample_done <= 1'b1;
          sample_avg  <= ADC_W'(avg_of(32'(acc_next), avg_sh));
          acc         <= '0;
          conv_cnt    <= '0;
        end else begin
          acc      <= acc_next;
          conv_cnt <= conv_cnt + 1'b1;
        end
      end else if (gap_fire) begin
        conv_req <= 1'b1;
        await_q  <= 1'b1;
      end else if (busy && !await_q && tick) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R4
  done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done |-> $past(adc_valid));

endmodule

// File: rtl/vslope_track.sv
module vslope_track
  import vslope_pkg::*;
#(
  parameter int unsigned ADC_W    = 12,
  parameter int unsigned TW       = 32,
  parameter int unsigned HOLD_LO  = 30000000,
  parameter int unsigned HOLD_MID = 60000000,
  parameter int unsigned HOLD_HI  = 15000000,
  parameter int unsigned PVD_DROP = 2,
  parameter int unsigned NDV_DROP = 10,
  parameter int unsigned WIN_LO   = 819,
  parameter int unsigned WIN_HI   = 1638
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic [1:0]       sel_q,
  input  logic             sample_done,
  input  logic [ADC_W-1:0] sample_avg,
  output logic             term
);
  logic [TW-1:0]    hold_cnt, hold_lim;
  logic             hold_done, peak_ok, fired;
  logic [ADC_W-1:0] peak;
  logic [31:0]      thr;
  logic             in_win, hit, detect;

  assign hold_lim = is_ndv(sel_q) ? TW'(HOLD_HI) : (sel_q[0] ? TW'(HOLD_MID) : TW'(HOLD_LO));
  assign thr      = is_ndv(sel_q) ? 32'(NDV_DROP) : 32'(PVD_DROP);
  assign in_win   = win_ok(32'(sample_avg), 32'(WIN_LO), 32'(WIN_HI));
  assign hit      = drop_hit(32'(peak), 32'(sample_avg), thr);
  assign detect   = sample_done && peak_ok && hold_done && in_win && hit && !fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0; hold_done <= 1'b0; peak_ok <= 1'b0;
      fired <= 1'b0; peak <= '0; term <= 1'b0;
    end else if (!active) begin
      hold_cnt <= '0; hold_done <= 1'b0; peak_ok <= 1'b0;
      fired <= 1'b0; peak <= '0; term <= 1'b0;
    end else begin
      term <= detect;
      if (detect) fired <= 1'b1;
      if (!hold_done && tick) begin
        if (hold_cnt == hold_lim - 1'b1) hold_done <= 1'b1;
        else hold_cnt <= hold_cnt + 1'b1;
      end
      if (sample_done && (!peak_ok || sample_avg > peak)) begin
        peak    <= sample_avg;
        peak_ok <= 1'b1;
      end
    end
  end

  // R9
  single_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> !$past(fired));

  // R8
  holdoff_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> $past(hold_done));

  // R9
  term_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> $past(sample_done));

endmodule

// File: rtl/vslope_det.sv
module vslope_det
  import vslope_pkg::*;
#(
  parameter int unsigned ADC_W      = 12,
  parameter int unsigned LOG2_PK    = 5,
  parameter int unsigned LOG2_ND    = 4,
  parameter int unsigned CONV_GAP   = 57,
  parameter int unsigned SAMPLE_GAP = 1700000,
  parameter int unsigned HOLD_LO    = 30000000,
  parameter int unsigned HOLD_MID   = 60000000,
  parameter int unsigned HOLD_HI    = 15000000,
  parameter int unsigned PVD_DROP   = 2,
  parameter int unsigned NDV_DROP   = 10,
  parameter int unsigned WIN_LO     = 819,
  parameter int unsigned WIN_HI     = 1638,
  parameter int unsigned TW         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       rate_sel,
  input  logic             tick,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             adc_valid,
  output logic             conv_req,
  output logic             term_pulse
);
  logic             en_q, active, sample_done;
  logic [1:0]       sel_q;
  logic [ADC_W-1:0] sample_avg;

  assign active = enable && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
    end else begin
      en_q <= enable;
      if (enable && !en_q) sel_q <= rate_sel;
    end
  end

  vslope_burst #(
    .ADC_W(ADC_W), .LOG2_PK(LOG2_PK), .LOG2_ND(LOG2_ND),
    .CONV_GAP(CONV_GAP), .SAMPLE_GAP(SAMPLE_GAP), .TW(TW)
  ) u_burst (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
    .nd_mode(is_ndv(sel_q)), .adc_data(adc_data), .adc_valid(adc_valid),
    .conv_req(conv_req), .sample_done(sample_done), .sample_avg(sample_avg)
  );

  vslope_track #(
    .ADC_W(ADC_W), .TW(TW), .HOLD_LO(HOLD_LO), .HOLD_MID(HOLD_MID), .HOLD_HI(HOLD_HI),
    .PVD_DROP(PVD_DROP), .NDV_DROP(NDV_DROP), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .sel_q(sel_q),
    .sample_done(sample_done), .sample_avg(sample_avg), .term(term_pulse)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!conv_req && !term_pulse));

  // R9
  term_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> !term_pulse);

endmodule

// File: tb/vslope_det_bench.sv
`timescale 1ns/1ps
module vslope_det_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic        tick = 1'b0;
  logic [11:0] adc_data = '0;
  logic        adc_valid = 1'b0;
  logic        conv_req, term_pulse;

  int tests = 0, fails = 0;
  int req_cnt = 0, term_cnt = 0, term_idx = -1, cur_bn = 32, idle_bad = 0;
  int sval [0:15];
  bit salt [0:15];
  bit sstray [0:15];
  bit over = 0;

  always #2.5 clk = ~clk;

  vslope_det #(
    .CONV_GAP(2), .SAMPLE_GAP(200), .HOLD_LO(420), .HOLD_MID(820), .HOLD_HI(180)
  ) u_vslope_det (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel), .tick(tick),
    .adc_data(adc_data), .adc_valid(adc_valid), .conv_req(conv_req), .term_pulse(term_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // tick every fourth clock
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // converter model: answers each request 3 clocks later
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req && enable) begin
        int idx, k, v;
        idx = req_cnt / cur_bn;
        if (idx > 15) idx = 15;
        k = req_cnt % cur_bn;
        v = sval[idx] + ((salt[idx] && (k % 2 == 1)) ? 3 : 0);
        req_cnt++;
        repeat (2) @(negedge clk);
        adc_data = 12'(v); adc_valid = 1'b1;
        @(negedge clk);
        adc_valid = 1'b0;
        if (sstray[idx] && k == 5) begin
          @(negedge clk);
          adc_data = 12'd1100; adc_valid = 1'b1;
          @(negedge clk);
          adc_valid = 1'b0;
        end
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!enable && rst_n && (conv_req || term_pulse)) idle_bad++;
      if (term_pulse) begin
        term_cnt++;
        term_idx = req_cnt / cur_bn - 1;
      end
    end
  end

  task automatic fill(input int v);
    for (int i = 0; i < 16; i++) begin sval[i] = v; salt[i] = 0; sstray[i] = 0; end
  endtask

  task automatic run_sess(input logic [1:0] m, input int nsamp, input int exp_idx,
                          input string req, input bit late);
    int bn;
    bn = m[1] ? 16 : 32;
    enable = 1'b0; rate_sel = m;
    repeat (4) @(negedge clk);
    req_cnt = 0; term_cnt = 0; term_idx = -1; cur_bn = bn;
    enable = 1'b1;
    if (late) begin repeat (10) @(negedge clk); rate_sel = 2'b00; end
    while (req_cnt < nsamp * bn) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(term_cnt == (exp_idx < 0 ? 0 : 1), {req, " pulse count"}, term_cnt, exp_idx < 0 ? 0 : 1);
    if (exp_idx >= 0) chk(term_idx == exp_idx, {req, " terminating sample"}, term_idx, exp_idx);
    chk(req_cnt == nsamp * bn, "R2 R3 requests per session", req_cnt, nsamp * bn);
    enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (conv_req || term_pulse) seen++;
    end
    chk(seen == 0, "R1 quiet after reset", seen, 0);
  endtask

  task automatic t_peak_exact();   // R6: drop of exactly PVD_DROP, then once only (R9)
    fill(1200); sval[1] = 1210; sval[2] = 1215; sval[3] = 1215; sval[4] = 1213;
    sval[5] = 1200; sval[6] = 1190;
    run_sess(2'b00, 7, 4, "R6 R9 low exact drop", 0);
  endtask

  task automatic t_peak_small();   // R6: drop of one LSB below threshold
    fill(1200); sval[1] = 1210; sval[2] = 1215; sval[3] = 1214; sval[4] = 1214; sval[5] = 1214;
    run_sess(2'b00, 6, -1, "R6 small drop", 0);
  endtask

  task automatic t_hold_low();     // R5 R8: peak set in hold-off, drop masked
    fill(1300); sval[1] = 1250; sval[2] = 1260;
    run_sess(2'b00, 3, 2, "R5 R8 low hold-off", 0);
  endtask

  task automatic t_hold_mid();     // R8: medium hold-off is longer
    fill(1250); sval[0] = 1200; sval[1] = 1300;
    run_sess(2'b01, 5, 4, "R8 mid hold-off", 0);
  endtask

  task automatic t_ndv();          // R3 R6 R10: 16-conversion bursts, 10 LSB, late select change
    fill(1200); sval[1] = 1300; sval[2] = 1291; sval[3] = 1290;
    run_sess(2'b10, 4, 3, "R3 R6 R10 high mode", 1);
  endtask

  task automatic t_win_hi();       // R7: above window cannot terminate
    fill(1700); sval[3] = 1650; sval[4] = 1600;
    run_sess(2'b00, 5, 4, "R7 upper window", 0);
  endtask

  task automatic t_win_lo();       // R7: below window cannot terminate
    fill(900); sval[3] = 800; sval[4] = 830;
    run_sess(2'b00, 5, 4, "R7 lower window", 0);
  endtask

  task automatic t_floor();        // R3: mean 1198.5 floors to 1198, a 2 LSB drop
    fill(1200); sval[3] = 1197; salt[3] = 1;
    run_sess(2'b00, 4, 3, "R3 floor average", 0);
  endtask

  task automatic t_stray();        // R4: unrequested strobes ignored
    fill(1200); sstray[2] = 1; sstray[3] = 1; sstray[4] = 1;
    run_sess(2'b00, 6, -1, "R4 stray strobes", 0);
  endtask

  task automatic t_reenable();     // R1: peak and hold-off cleared across sessions
    fill(1400);
    run_sess(2'b00, 2, -1, "R1 first session", 0);
    fill(1300);
    run_sess(2'b00, 4, -1, "R1 fresh session", 0);
  endtask

  initial begin
    fill(1200);
    t_reset();
    t_peak_exact();
    t_peak_small();
    t_hold_low();
    t_hold_mid();
    t_ndv();
    t_win_hi();
    t_win_lo();
    t_floor();
    t_stray();
    t_reenable();
    chk(idle_bad == 0, "R1 outputs while disabled", idle_bad, 0);
    over = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!over) begin
      tests++; fails++;
      $display("FAIL watchdog R2 run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule